// File: doc/BRIEF.md
# Single-Bit Test-and-Modify Unit

This block performs the single-bit operations of a processor execution stage. It takes a 32-bit operand, a bit number, a size select and a two-bit operation code. It picks one bit of the operand and records that bit's state in the zero flag. It then leaves the bit as it was, sets it, clears it or inverts it. The other condition flags go through untouched. A write-enable tells the surrounding datapath whether the modified operand must be stored back. For a pure test there is nothing to store.

The size select chooses between a narrow target, the low byte as used for memory operands, and a wide target, the full word as used for register operands. The bit number may come from a register or from an immediate field. It is always wrapped to the width of the chosen target. Results leave through a single registered stage with a valid/ready handshake, so a stalled consumer holds the result in place. Operand fetch and address generation stay outside the block.

Top module: `bitop_unit`

## Requirements
- R1: `out_ccr` bit 2 (zero) equals the inverse of the selected input bit as it was before any change, for every operation code, so it is 1 when that bit was 0.
- R2: Operation code `in_op` encodings are 00 test only (operand unchanged), 01 invert the selected bit, 10 clear it, 11 set it.
- R3: No bit other than the selected one ever differs between `in_operand` and `out_operand`.
- R4: With `in_size` = 0 (byte target) the bit number is taken modulo 8, and bits 31:8 of the output equal the input.
- R5: With `in_size` = 1 (longword target) the bit number is taken modulo 32.
- R6: `in_ccr`/`out_ccr` are packed as {extend, negative, zero, overflow, carry} in bits 4..0. Bits 4, 3, 1 and 0 are copied from input to output unchanged.
- R7: `out_wr_en` is 0 for the test-only code and 1 for the other three codes.
- R8: A transfer is accepted at a rising edge where `in_valid` and `in_ready` are both 1. Its result is presented with `out_valid` = 1 after that edge and is held stable while `out_ready` is 0.
- R9: `in_ready` is 1 exactly when the output stage is empty or `out_ready` is 1. A new transfer may be captured at the same edge that hands off the previous result. Without a new transfer, a hand-off empties the stage.
- R10: Synchronous active-high reset `rst` empties the output stage (`out_valid` = 0), discarding any held result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request carries a valid operation |
| in_ready | output | 1 | Unit can accept a request this cycle |
| in_operand | input | 32 | Operand to test and modify |
| in_bitno | input | 8 | Bit number from register or immediate, wrapped by size |
| in_size | input | 1 | 0 byte target, 1 longword target |
| in_op | input | 2 | Operation code (R2) |
| in_ccr | input | 5 | Incoming condition flags {X,N,Z,V,C} |
| out_valid | output | 1 | Result held in the output stage |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_operand | output | 32 | Operand after modification |
| out_ccr | output | 5 | Flags with new zero, others passed through |
| out_wr_en | output | 1 | Store-back needed (0 for test only) |

## Verification
Two functions of the output stage can fall in the same edge: handing off a held result and capturing a new request. The bench provokes this by first stalling the consumer with a result held, then offering a second request. While the stall lasts, it checks that `in_ready` is low and the old result stays put. It then releases `out_ready` while the second request is still offered, and requires the second result to appear with `out_valid` still high right after that edge. Around this, a full sweep of every operation code, both sizes, all 256 bit numbers and several operand patterns compares each result with values computed arithmetically in the bench.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    localparam int OPND_W   = 32;
    localparam int NARROW_W = 8;
    localparam int BITNO_W  = 8;
    localparam int CCR_W    = 5;

    localparam logic [BITNO_W-1:0] WIDE_WRAP   = BITNO_W'(OPND_W - 1);
    localparam logic [BITNO_W-1:0] NARROW_WRAP = BITNO_W'(NARROW_W - 1);

    typedef enum logic [1:0] {
        BOP_PROBE = 2'b00,
        BOP_FLIP  = 2'b01,
        BOP_CLEAR = 2'b10,
        BOP_SET   = 2'b11
    } bop_e;

    typedef enum logic {
        SZ_NARROW = 1'b0,
        SZ_WIDE   = 1'b1
    } bsz_e;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    typedef struct packed {
        logic [OPND_W-1:0] data;
        ccr_t              ccr;
        logic              wr_en;
    } bop_res_t;

    function automatic logic [BITNO_W-1:0] wrap_bitno(
        input logic [BITNO_W-1:0] n,
        input bsz_e               sz
    );
        return n & ((sz == SZ_WIDE) ? WIDE_WRAP : NARROW_WRAP);
    endfunction

    function automatic logic needs_store(input bop_e op);
        return op != BOP_PROBE;
    endfunction

endpackage

// File: rtl/bitop_select.sv
module bitop_select
    import bitop_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               chk_en,
    input  logic [BITNO_W-1:0] bitno,
    input  bsz_e               size,
    output logic [OPND_W-1:0]  mask
);

    logic [BITNO_W-1:0] wrapped;

    assign wrapped = wrap_bitno(bitno, size);

    for (genvar i = 0; i < OPND_W; i++) begin : g_dec
        assign mask[i] = (wrapped == BITNO_W'(i));
    end

    always_ff @(posedge clk) begin
        if (!rst && chk_en) begin
            AST_ONE_TARGET: assert ($countones(mask) == 1)
                else $error("mask not one-hot"); // R5
            if (size == SZ_NARROW)
                AST_NARROW_HIGH_QUIET: assert (mask[OPND_W-1:NARROW_W] == '0)
                    else $error("byte target selects a high bit"); // R4
        end
    end

endmodule

// File: rtl/bitop_apply.sv
module bitop_apply
    import bitop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              chk_en,
    input  logic [OPND_W-1:0] operand,
    input  logic [OPND_W-1:0] mask,
    input  bop_e              op,
    output logic [OPND_W-1:0] data,
    output logic              old_bit,
    output logic              wr_en
);

    always_comb begin
        unique case (op)
            BOP_FLIP:  data = operand ^ mask;
            BOP_CLEAR: data = operand & ~mask;
            BOP_SET:   data = operand | mask;
            default:   data = operand;
        endcase
    end

    assign old_bit = |(operand & mask);
    assign wr_en   = needs_store(op);

    always_ff @(posedge clk) begin
        if (!rst && chk_en) begin
            AST_SINGLE_BIT_CHANGE: assert ($countones(data ^ operand) <= 1)
                else $error("more than one bit changed"); // R3
            if (op == BOP_PROBE)
                AST_PROBE_KEEPS: assert (data == operand)
                    else $error("test-only altered operand"); // R2
            if (op == BOP_SET)
                AST_SET_LANDS: assert ((data & mask) == mask)
                    else $error("set left bit low"); // R2
        end
    end

endmodule

// File: rtl/bitop_flags.sv
module bitop_flags
    import bitop_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic chk_en,
    input  ccr_t ccr_in,
    input  logic old_bit,
    output ccr_t ccr_out
);

    always_comb begin
        ccr_out   = ccr_in;
        ccr_out.z = ~old_bit;
    end

    always_ff @(posedge clk) begin
        if (!rst && chk_en) begin
            AST_FLAGS_KEPT: assert ({ccr_out.x, ccr_out.n, ccr_out.v, ccr_out.c}
                                 == {ccr_in.x, ccr_in.n, ccr_in.v, ccr_in.c})
                else $error("untouched flag changed"); // R6
        end
    end

endmodule

// File: rtl/bitop_stage.sv
module bitop_stage
    import bitop_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    output logic     in_ready,
    input  bop_res_t in_payload,
    output logic     out_valid,
    input  logic     out_ready,
    output bop_res_t out_payload
);

    logic take;

    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else if (take) begin
            out_valid <= 1'b1;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (take) begin
            out_payload <= in_payload;
        end
    end

    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_payload)))
        else $error("result moved during stall"); // R8

    AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !in_valid) |=> !out_valid)
        else $error("stage not emptied after hand-off"); // R9

    AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid)
        else $error("accepted request not presented"); // R8

    AST_RESET_EMPTY: assert property (@(posedge clk)
        rst |=> !out_valid)
        else $error("reset did not empty stage"); // R10

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [OPND_W-1:0]  in_operand,
    input  logic [BITNO_W-1:0] in_bitno,
    input  logic               in_size,
    input  logic [1:0]         in_op,
    input  logic [CCR_W-1:0]   in_ccr,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [OPND_W-1:0]  out_operand,
    output logic [CCR_W-1:0]   out_ccr,
    output logic               out_wr_en
);

    bsz_e              size_q;
    bop_e              op_q;
    ccr_t              ccr_q;
    logic [OPND_W-1:0] mask;
    logic [OPND_W-1:0] mod_data;
    logic              old_bit;
    logic              wr_en;
    ccr_t              ccr_new;
    bop_res_t          res_in;
    bop_res_t          res_out;

    assign size_q = bsz_e'(in_size);
    assign op_q   = bop_e'(in_op);
    assign ccr_q  = ccr_t'(in_ccr);

    bitop_select u_select (
        .clk    (clk),
        .rst    (rst),
        .chk_en (in_valid),
        .bitno  (in_bitno),
        .size   (size_q),
        .mask   (mask)
    );

    bitop_apply u_apply (
        .clk     (clk),
        .rst     (rst),
        .chk_en  (in_valid),
        .operand (in_operand),
        .mask    (mask),
        .op      (op_q),
        .data    (mod_data),
        .old_bit (old_bit),
        .wr_en   (wr_en)
    );

    bitop_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .chk_en  (in_valid),
        .ccr_in  (ccr_q),
        .old_bit (old_bit),
        .ccr_out (ccr_new)
    );

    always_comb begin
        res_in.data  = mod_data;
        res_in.ccr   = ccr_new;
        res_in.wr_en = wr_en;
    end

    bitop_stage u_stage (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_payload  (res_in),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_payload (res_out)
    );

    assign out_operand = res_out.data;
    assign out_ccr     = res_out.ccr;
    assign out_wr_en   = res_out.wr_en;

endmodule

// File: tb/tb_bitop_unit.sv
module tb_bitop_unit;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_operand = '0;
    logic [7:0]  in_bitno = '0;
    logic        in_size = 1'b0;
    logic [1:0]  in_op = 2'b00;
    logic [4:0]  in_ccr = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_operand;
    logic [4:0]  out_ccr;
    logic        out_wr_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    bitop_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_operand(in_operand), .in_bitno(in_bitno), .in_size(in_size),
        .in_op(in_op), .in_ccr(in_ccr), .out_valid(out_valid),
        .out_ready(out_ready), .out_operand(out_operand),
        .out_ccr(out_ccr), .out_wr_en(out_wr_en)
    );

    function automatic int idx_of(input logic [7:0] n, input logic sz);
        return sz ? int'(n % 32) : int'(n % 8);
    endfunction

    function automatic logic [31:0] exp_data(input logic [31:0] d, input logic [7:0] n,
                                             input logic sz, input logic [1:0] op);
        logic [31:0] m;
        m = 32'd1 << idx_of(n, sz);
        case (op)
            2'b01:   return d ^ m;
            2'b10:   return d & ~m;
            2'b11:   return d | m;
            default: return d;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] d, input logic [7:0] n, input logic sz,
                         input logic [1:0] op, input logic [4:0] f);
        in_operand = d; in_bitno = n; in_size = sz; in_op = op; in_ccr = f;
        in_valid = 1'b1;
    endtask

    task automatic verify(input logic [31:0] d, input logic [7:0] n, input logic sz,
                          input logic [1:0] op, input logic [4:0] f);
        logic [31:0] ed;
        logic        ez;
        ed = exp_data(d, n, sz, op);
        ez = ~d[idx_of(n, sz)];
        check(out_valid == 1'b1, "R8", 32'(out_valid), 32'd1);
        check(out_operand == ed, sz ? "R2 R5" : "R2 R4", out_operand, ed);
        if (!sz)
            check(out_operand[31:8] == d[31:8], "R4", out_operand, d);
        check($countones(out_operand ^ d) <= 1, "R3", out_operand, d);
        check(out_ccr[2] == ez, "R1", 32'(out_ccr[2]), 32'(ez));
        check({out_ccr[4:3], out_ccr[1:0]} == {f[4:3], f[1:0]}, "R6",
              32'(out_ccr), 32'(f));
        check(out_wr_en == (op != 2'b00), "R7", 32'(out_wr_en), 32'(op != 2'b00));
    endtask

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'h0000_0000;
        pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'hA5C3_0F96;
        pats[3] = 32'h1234_5678;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R10", 32'(out_valid), 32'd0);
        check(in_ready == 1'b1, "R9", 32'(in_ready), 32'd1);

        // Full sweep: every op, both sizes, every bit number
        for (int p = 0; p < 4; p++) begin
            for (int sz = 0; sz < 2; sz++) begin
                for (int op = 0; op < 4; op++) begin
                    for (int n = 0; n < 256; n++) begin
                        logic [4:0] f;
                        f = 5'(n ^ (op * 7) ^ p);
                        drive(pats[p], 8'(n), 1'(sz), 2'(op), f);
                        @(posedge clk);
                        @(negedge clk);
                        in_valid = 1'b0;
                        verify(pats[p], 8'(n), 1'(sz), 2'(op), f);
                    end
                end
            end
        end
        @(negedge clk);
        check(out_valid == 1'b0, "R9", 32'(out_valid), 32'd0);

        // Stall, then hand-off and capture at the same edge
        out_ready = 1'b0;
        drive(32'h0F0F_0000, 8'd3, 1'b0, 2'b11, 5'b10101);
        @(posedge clk);
        @(negedge clk);
        drive(32'hCAFE_0001, 8'd40, 1'b1, 2'b01, 5'b01010);
        #1;
        check(in_ready == 1'b0, "R9", 32'(in_ready), 32'd0);
        verify(32'h0F0F_0000, 8'd3, 1'b0, 2'b11, 5'b10101);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(out_operand == 32'h0F0F_0008, "R8", out_operand, 32'h0F0F_0008);
            check(in_ready == 1'b0, "R9", 32'(in_ready), 32'd0);
        end
        out_ready = 1'b1;
        #1;
        check(in_ready == 1'b1, "R9", 32'(in_ready), 32'd1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        verify(32'hCAFE_0001, 8'd40, 1'b1, 2'b01, 5'b01010);
        @(negedge clk);
        check(out_valid == 1'b0, "R9", 32'(out_valid), 32'd0);

        // Reset discards a held result
        out_ready = 1'b0;
        drive(32'h0000_00FF, 8'd7, 1'b0, 2'b10, 5'b00000);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, "R8", 32'(out_valid), 32'd1);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R10", 32'(out_valid), 32'd0);
        rst = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule